// File: doc/BRIEF.md
# Quad-Lane Serial Flash Command Front End

This block is the target-side command front end of a serial flash device that moves data over four I/O lines. It runs on the serial clock. On each rising edge while chip select is low it samples one nibble, and it pairs each two nibbles into a byte. The first byte of a transfer is the opcode. The opcode decides how many address and dummy bytes follow, and whether the transfer then streams read data out on the four lines or takes in program data.

Decoded operations go to a back end through a single one-cycle command strobe, which carries the opcode, the address and an argument byte. Read data is pulled byte by byte from the back end through a fetch strobe. Program data bytes are handed over through a write strobe. A write-enable latch guards every program and erase command. A two-step arm guards the reset command.

The block treats the serial clock as its clock and samples chip select on the same edges. A chip-select level seen high on a rising edge ends the transfer and returns the block to opcode collection. The output enable drops as soon as chip select rises.

Top module: `qio_front`

## Requirements
- R1: Each byte is received as two nibbles on consecutive rising edges, and the first nibble becomes bits 7:4. Address bytes are taken most significant byte first, so `cmd_addr` holds the 24-bit address in that order.
- R2: Opcode 03h takes three address bytes and opcode 0Bh takes three address bytes plus one dummy byte. For both, `cmd_valid` with the opcode and address appears in the cycle after the edge that completes the last address or dummy byte. It never appears earlier.
- R3: In a read, `rd_req` is high in the first cycle after the command completes, while `io_oe` is still low. On the next edge the fetched byte `rd_data` is captured. The bus then drives bits 7:4 for one cycle and bits 3:0 for the next, and `rd_req` is high again during that second cycle. This repeats until chip select rises, and `io_oe` falls in the same instant that `cs_n` goes high.
- R4: Opcode 05h drives the status byte repeatedly with the same nibble timing as R3 and without `rd_req`. The status byte is `stat_in` with bit 1 replaced by the write-enable latch.
- R5: Opcode 06h sets the write-enable latch and opcode 04h clears it. Neither raises `cmd_valid`.
- R6: Opcodes 02h, 20h, D8h and C7h raise no `cmd_valid` and no `wr_valid` while the write-enable latch is clear.
- R7: When 02h, 20h, D8h or C7h is issued on `cmd_valid`, the write-enable latch clears.
- R8: For an accepted 02h, `cmd_valid` follows the third address byte. Each later data byte then gives one `wr_valid` pulse carrying that byte. At most 256 pulses are given, and further bytes are ignored.
- R9: If `cs_n` rises before the last nibble of an instruction, the instruction has no effect: no strobe is raised and the latch is unchanged. The next transfer starts again at an opcode.
- R10: Opcode 99h raises `cmd_valid` only when the opcode just before it was 66h. Any other opcode in between cancels the arm.
- R11: An opcode outside the supported set raises no strobe and never enables the output drivers for the rest of the transfer.
- R12: Opcode C0h raises `cmd_valid` after one further byte, with that byte on `cmd_arg`. Opcodes B0h and 30h raise `cmd_valid` directly after the opcode byte.
- R13: `cmd_valid` and `wr_valid` are single-cycle pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sck | input | 1 | Serial clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select framing each transfer |
| io_in | input | 4 | Nibble sampled from the four data lines |
| io_out | output | 4 | Nibble driven on the four data lines during reads |
| io_oe | output | 1 | Output enable for the four data lines |
| rd_req | output | 1 | Fetch strobe; back end presents the next read byte in the same cycle |
| rd_data | input | 8 | Read byte from the back end |
| stat_in | input | 8 | Status bits from the back end |
| wr_valid | output | 1 | Program data byte strobe |
| wr_data | output | 8 | Program data byte |
| cmd_valid | output | 1 | Decoded command strobe |
| cmd_op | output | 8 | Opcode of the issued command |
| cmd_addr | output | 24 | Address of the issued command |
| cmd_arg | output | 8 | Argument byte (burst length for C0h) |

## Verification
The bound checker watches four things on every cycle. It checks that each command strobe lasts one cycle. It checks that a guarded command is issued only with the latch set beforehand, and that the latch is clear after the issue. It checks that a reset command is seen only after a prior arm. It checks that a fetch is followed by a driven bus unless chip select has risen, and that the ignore state never drives. The bench shows the rest through its scenarios: nibble order and address assembly, the exact cycle of the turnaround and the byte stream, status repetition, the 256-byte cap, aborts partway through a nibble, and the response of all 256 opcodes in a sweep.

// File: rtl/qio_pkg.sv
`timescale 1ns/1ps
package qio_pkg;
  localparam int QNIB  = 4;
  localparam int QBYTE = 2 * QNIB;

  typedef enum logic [3:0] {
    K_UNKNOWN, K_NOP, K_WREN, K_WRDI, K_RSTEN, K_RST, K_PLAIN, K_CHIP,
    K_STAT, K_READ, K_FREAD, K_PROG, K_ERASE, K_BURST
  } qop_kind_e;

  typedef enum logic [2:0] {
    S_OP, S_ADDR, S_DUMMY, S_RD, S_WR, S_ARG, S_HOLD
  } qphase_e;

  function automatic qop_kind_e classify(input logic [QBYTE-1:0] op);
    case (op)
      8'h00: classify = K_NOP;
      8'h06: classify = K_WREN;
      8'h04: classify = K_WRDI;
      8'h66: classify = K_RSTEN;
      8'h99: classify = K_RST;
      8'hB0, 8'h30: classify = K_PLAIN;
      8'hC7: classify = K_CHIP;
      8'h05: classify = K_STAT;
      8'h03: classify = K_READ;
      8'h0B: classify = K_FREAD;
      8'h02: classify = K_PROG;
      8'h20, 8'hD8: classify = K_ERASE;
      8'hC0: classify = K_BURST;
      default: classify = K_UNKNOWN;
    endcase
  endfunction

  function automatic logic is_guarded(input logic [QBYTE-1:0] op);
    qop_kind_e k;
    k = classify(op);
    return (k == K_PROG) || (k == K_ERASE) || (k == K_CHIP);
  endfunction

  function automatic logic takes_input(input qphase_e p);
    return (p == S_OP) || (p == S_ADDR) || (p == S_DUMMY) || (p == S_WR) || (p == S_ARG);
  endfunction
endpackage

// File: rtl/qio_nib_pack.sv
`timescale 1ns/1ps
module qio_nib_pack import qio_pkg::*; (
  input  logic             sck,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             en,
  input  logic [QNIB-1:0]  nib_in,
  output logic             byte_ev,
  output logic [QBYTE-1:0] byte_val
);
  logic            second_q;
  logic [QNIB-1:0] upper_q;

  always_ff @(posedge sck or negedge rst_n) begin
    if (!rst_n) begin
      second_q <= 1'b0;
      upper_q  <= '0;
    end else if (cs_n) begin
      second_q <= 1'b0;
    end else if (en) begin
      if (!second_q) upper_q <= nib_in;
      second_q <= !second_q;
    end
  end

  assign byte_ev  = !cs_n && en && second_q;
  assign byte_val = {upper_q, nib_in};
endmodule

// File: rtl/qio_rd_drive.sv
`timescale 1ns/1ps
module qio_rd_drive import qio_pkg::*; (
  input  logic             sck,
  input  logic             rst_n,
  input  logic             active,
  input  logic [QBYTE-1:0] src,
  output logic             need,
  output logic [QNIB-1:0]  nib_out,
  output logic             oe
);
  logic [QBYTE-1:0] hold_q;
  logic             loaded_q;
  logic             low_q;

  assign need = active && (!loaded_q || low_q);

  always_ff @(posedge sck or negedge rst_n) begin
    if (!rst_n) begin
      hold_q   <= '0;
      loaded_q <= 1'b0;
      low_q    <= 1'b0;
    end else if (!active) begin
      loaded_q <= 1'b0;
      low_q    <= 1'b0;
    end else if (need) begin
      hold_q   <= src;
      loaded_q <= 1'b1;
      low_q    <= 1'b0;
    end else begin
      low_q    <= 1'b1;
    end
  end

  assign nib_out = low_q ? hold_q[QNIB-1:0] : hold_q[QBYTE-1:QNIB];
  assign oe      = active && loaded_q;
endmodule

// File: rtl/qio_front.sv
`timescale 1ns/1ps
module qio_front import qio_pkg::*; #(
  parameter int ADDR_BYTES  = 3,
  parameter int DUMMY_BYTES = 1,
  parameter int MAX_PROG    = 256,
  parameter int WEL_BIT     = 1
) (
  input  logic                    sck,
  input  logic                    rst_n,
  input  logic                    cs_n,
  input  logic [3:0]              io_in,
  output logic [3:0]              io_out,
  output logic                    io_oe,
  output logic                    rd_req,
  input  logic [7:0]              rd_data,
  input  logic [7:0]              stat_in,
  output logic                    wr_valid,
  output logic [7:0]              wr_data,
  output logic                    cmd_valid,
  output logic [7:0]              cmd_op,
  output logic [8*ADDR_BYTES-1:0] cmd_addr,
  output logic [7:0]              cmd_arg
);
  localparam int AW = QBYTE * ADDR_BYTES;
  localparam int CW = $clog2(ADDR_BYTES + DUMMY_BYTES + 1);
  localparam int WW = $clog2(MAX_PROG + 1);
  localparam logic [CW-1:0] LAST_A = CW'(ADDR_BYTES - 1);
  localparam logic [CW-1:0] LAST_D = CW'((DUMMY_BYTES > 0) ? DUMMY_BYTES - 1 : 0);
  localparam logic [WW-1:0] LAST_W = WW'(MAX_PROG - 1);

  qphase_e          st_q, st_d;
  qop_kind_e        kind_q, kind_d;
  logic [QBYTE-1:0] op_q, op_d;
  logic [AW-1:0]    addr_q, addr_d, addr_nx;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [WW-1:0]    wcnt_q, wcnt_d;
  logic             wel_q, wel_d;
  logic             arm_q, arm_d;
  logic             stat_q, stat_d;

  logic             byte_ev;
  logic [QBYTE-1:0] byte_val;
  logic             issue_ev;
  logic             wr_ev;
  logic [QBYTE-1:0] iss_op, iss_arg;
  logic [AW-1:0]    iss_addr;
  logic             hold_w;
  logic             rd_active;
  logic             fetch;
  logic [QBYTE-1:0] stat_byte, fetch_src;

  qio_nib_pack u_pack (
    .sck(sck), .rst_n(rst_n), .cs_n(cs_n), .en(takes_input(st_q)),
    .nib_in(io_in), .byte_ev(byte_ev), .byte_val(byte_val)
  );

  always_comb begin
    stat_byte          = stat_in;
    stat_byte[WEL_BIT] = wel_q;
  end

  assign addr_nx   = {addr_q[AW-QBYTE-1:0], byte_val};
  assign rd_active = !cs_n && (st_q == S_RD);
  assign fetch_src = stat_q ? stat_byte : rd_data;
  assign hold_w    = (st_q == S_HOLD);

  qio_rd_drive u_drv (
    .sck(sck), .rst_n(rst_n), .active(rd_active), .src(fetch_src),
    .need(fetch), .nib_out(io_out), .oe(io_oe)
  );

  assign rd_req = fetch && !stat_q;

  always_comb begin
    st_d     = st_q;
    kind_d   = kind_q;
    op_d     = op_q;
    addr_d   = addr_q;
    cnt_d    = cnt_q;
    wcnt_d   = wcnt_q;
    wel_d    = wel_q;
    arm_d    = arm_q;
    stat_d   = stat_q;
    issue_ev = 1'b0;
    wr_ev    = 1'b0;
    iss_op   = op_q;
    iss_addr = addr_nx;
    iss_arg  = byte_val;
    if (cs_n) begin
      st_d   = S_OP;
      cnt_d  = '0;
      wcnt_d = '0;
      stat_d = 1'b0;
    end else if (byte_ev) begin
      case (st_q)
        S_OP: begin
          op_d     = byte_val;
          iss_op   = byte_val;
          iss_addr = '0;
          kind_d   = classify(byte_val);
          arm_d    = (kind_d == K_RSTEN);
          cnt_d    = '0;
          wcnt_d   = '0;
          addr_d   = '0;
          st_d     = S_HOLD;
          case (kind_d)
            K_WREN:  wel_d = 1'b1;
            K_WRDI:  wel_d = 1'b0;
            K_RST:   issue_ev = arm_q;
            K_PLAIN: issue_ev = 1'b1;
            K_CHIP: begin
              issue_ev = wel_q;
              wel_d    = 1'b0;
            end
            K_STAT: begin
              st_d   = S_RD;
              stat_d = 1'b1;
            end
            K_READ, K_FREAD, K_PROG, K_ERASE: st_d = S_ADDR;
            K_BURST: st_d = S_ARG;
            default: ;
          endcase
        end
        S_ADDR: begin
          addr_d = addr_nx;
          cnt_d  = cnt_q + 1'b1;
          if (cnt_q == LAST_A) begin
            cnt_d = '0;
            case (kind_q)
              K_READ: begin
                issue_ev = 1'b1;
                st_d     = S_RD;
              end
              K_FREAD: begin
                if (DUMMY_BYTES == 0) begin
                  issue_ev = 1'b1;
                  st_d     = S_RD;
                end else begin
                  st_d = S_DUMMY;
                end
              end
              K_PROG: begin
                issue_ev = wel_q;
                wel_d    = 1'b0;
                st_d     = wel_q ? S_WR : S_HOLD;
              end
              K_ERASE: begin
                issue_ev = wel_q;
                wel_d    = 1'b0;
                st_d     = S_HOLD;
              end
              default: st_d = S_HOLD;
            endcase
          end
        end
        S_DUMMY: begin
          cnt_d    = cnt_q + 1'b1;
          iss_addr = addr_q;
          if (cnt_q == LAST_D) begin
            issue_ev = 1'b1;
            st_d     = S_RD;
          end
        end
        S_WR: begin
          wr_ev  = 1'b1;
          wcnt_d = wcnt_q + 1'b1;
          if (wcnt_q == LAST_W) st_d = S_HOLD;
        end
        S_ARG: begin
          issue_ev = 1'b1;
          iss_addr = '0;
          st_d     = S_HOLD;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge sck or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= S_OP;
      kind_q    <= K_UNKNOWN;
      op_q      <= '0;
      addr_q    <= '0;
      cnt_q     <= '0;
      wcnt_q    <= '0;
      wel_q     <= 1'b0;
      arm_q     <= 1'b0;
      stat_q    <= 1'b0;
      cmd_valid <= 1'b0;
      cmd_op    <= '0;
      cmd_addr  <= '0;
      cmd_arg   <= '0;
      wr_valid  <= 1'b0;
      wr_data   <= '0;
    end else begin
      st_q      <= st_d;
      kind_q    <= kind_d;
      op_q      <= op_d;
      addr_q    <= addr_d;
      cnt_q     <= cnt_d;
      wcnt_q    <= wcnt_d;
      wel_q     <= wel_d;
      arm_q     <= arm_d;
      stat_q    <= stat_d;
      cmd_valid <= issue_ev;
      wr_valid  <= wr_ev;
      if (issue_ev) begin
        cmd_op   <= iss_op;
        cmd_addr <= iss_addr;
        cmd_arg  <= iss_arg;
      end
      if (wr_ev) wr_data <= byte_val;
    end
  end
endmodule

// File: rtl/qio_front_chk.sv
`timescale 1ns/1ps
module qio_front_chk import qio_pkg::*; (
  input logic       sck,
  input logic       rst_n,
  input logic       cs_n,
  input logic       io_oe,
  input logic       rd_req,
  input logic       cmd_valid,
  input logic [7:0] cmd_op,
  input logic       wr_valid,
  input logic       wel,
  input logic       arm,
  input logic       hold
);
  assert_fetch_then_drive_R3: assert property (@(posedge sck) disable iff (!rst_n)
    rd_req |=> (io_oe || cs_n)) else $error("fetch not followed by drive");

  assert_guard_needs_wel_R6: assert property (@(posedge sck) disable iff (!rst_n)
    (cmd_valid && is_guarded(cmd_op)) |-> $past(wel)) else $error("guarded command without latch");

  assert_guard_clears_wel_R7: assert property (@(posedge sck) disable iff (!rst_n)
    (cmd_valid && is_guarded(cmd_op)) |-> !wel) else $error("latch survived issue");

  assert_reset_armed_R10: assert property (@(posedge sck) disable iff (!rst_n)
    (cmd_valid && cmd_op == 8'h99) |-> $past(arm)) else $error("reset issued unarmed");

  assert_skip_silent_R11: assert property (@(posedge sck) disable iff (!rst_n)
    hold |-> !io_oe) else $error("drive while ignoring");

  assert_cmd_pulse_R13: assert property (@(posedge sck) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid) else $error("command strobe too long");

  assert_wr_pulse_R13: assert property (@(posedge sck) disable iff (!rst_n)
    wr_valid |=> !wr_valid) else $error("write strobe too long");
endmodule

bind qio_front qio_front_chk u_chk (
  .sck(sck), .rst_n(rst_n), .cs_n(cs_n), .io_oe(io_oe), .rd_req(rd_req),
  .cmd_valid(cmd_valid), .cmd_op(cmd_op), .wr_valid(wr_valid),
  .wel(wel_q), .arm(arm_q), .hold(hold_w)
);

// File: tb/tb_qio_front.sv
`timescale 1ns/1ps
module tb_qio_front;
  logic        sck = 1'b0;
  logic        rst_n, cs_n;
  logic [3:0]  io_in, io_out;
  logic        io_oe, rd_req, wr_valid, cmd_valid;
  logic [7:0]  rd_data, stat_in, wr_data, cmd_op, cmd_arg;
  logic [23:0] cmd_addr, be_ptr;

  int checks = 0, fails = 0, ncmd = 0, nwr = 0;
  bit seen_oe = 0, done = 0;
  logic [7:0] wbuf [0:511];

  always #4 sck = ~sck;

  qio_front dut (
    .sck(sck), .rst_n(rst_n), .cs_n(cs_n), .io_in(io_in), .io_out(io_out),
    .io_oe(io_oe), .rd_req(rd_req), .rd_data(rd_data), .stat_in(stat_in),
    .wr_valid(wr_valid), .wr_data(wr_data), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_arg(cmd_arg)
  );

  function automatic logic [7:0] mem_at(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hC3;
  endfunction

  // back end model: serves bytes from the address of the last read command
  assign rd_data = mem_at(cmd_valid ? cmd_addr : be_ptr);
  always @(posedge sck) if (rd_req) be_ptr <= (cmd_valid ? cmd_addr : be_ptr) + 24'd1;

  always @(negedge sck) begin
    if (cmd_valid) ncmd++;
    if (wr_valid) begin
      if (nwr < 512) wbuf[nwr] = wr_data;
      nwr++;
    end
    if (io_oe) seen_oe = 1;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic nib(input logic [3:0] n);
    io_in = n;
    @(negedge sck);
  endtask
  task automatic send_byte(input logic [7:0] b);
    nib(b[7:4]);
    nib(b[3:0]);
  endtask
  task automatic begin_cs;
    @(negedge sck);
    cs_n = 1'b0;
  endtask
  task automatic end_cs;
    cs_n = 1'b1;
    @(negedge sck);
    @(negedge sck);
    #1;
  endtask
  task automatic op1(input logic [7:0] b);
    begin_cs;
    send_byte(b);
    end_cs;
  endtask

  task automatic rd_stream(input int n, input logic [23:0] a);
    check(rd_req === 1'b1 && io_oe === 1'b0, "R3 turnaround", {rd_req, io_oe}, 2'b10);
    for (int k = 0; k < n; k++) begin
      logic [7:0] e;
      e = mem_at(a + 24'(k));
      @(negedge sck);
      check(io_oe === 1'b1 && io_out === e[7:4], "R3 upper nibble", {io_oe, io_out}, {1'b1, e[7:4]});
      @(negedge sck);
      check(io_out === e[3:0] && rd_req === 1'b1, "R3 lower nibble", {rd_req, io_out}, {1'b1, e[3:0]});
    end
  endtask

  task automatic stat_read(input int n, input logic [7:0] e);
    begin_cs;
    send_byte(8'h05);
    check(rd_req === 1'b0 && io_oe === 1'b0, "R4 status turnaround", {rd_req, io_oe}, 0);
    for (int k = 0; k < n; k++) begin
      @(negedge sck);
      check(io_oe === 1'b1 && io_out === e[7:4], "R4 status upper", io_out, e[7:4]);
      @(negedge sck);
      check(io_out === e[3:0] && rd_req === 1'b0, "R4 status lower", io_out, e[3:0]);
    end
    end_cs;
  endtask

  initial begin
    int c, w;
    cs_n = 1'b1; io_in = '0; rst_n = 1'b0; stat_in = 8'hA5; be_ptr = '0;
    repeat (4) @(negedge sck);
    check(io_oe === 1'b0 && rd_req === 1'b0 && cmd_valid === 1'b0 && wr_valid === 1'b0,
          "R13 reset quiet", {io_oe, rd_req, cmd_valid, wr_valid}, 0);
    rst_n = 1'b1;
    @(negedge sck);

    // R1 R2 R3: plain read
    begin_cs;
    send_byte(8'h03); send_byte(8'h12); send_byte(8'hA5); send_byte(8'hC3);
    check(cmd_valid && cmd_op == 8'h03 && cmd_addr == 24'h12A5C3, "R1 R2 read address", cmd_addr, 24'h12A5C3);
    rd_stream(4, 24'h12A5C3);
    cs_n = 1'b1; #1;
    check(io_oe === 1'b0, "R3 release on cs rise", io_oe, 0);
    end_cs;

    // R2: fast read with dummy byte
    begin_cs;
    send_byte(8'h0B); send_byte(8'h00); send_byte(8'h01); send_byte(8'hFF);
    check(!cmd_valid && !rd_req && !io_oe, "R2 dummy pending", {cmd_valid, rd_req, io_oe}, 0);
    send_byte(8'h00);
    check(cmd_valid && cmd_op == 8'h0B && cmd_addr == 24'h0001FF, "R2 fast read issue", cmd_addr, 24'h0001FF);
    rd_stream(3, 24'h0001FF);
    end_cs;

    // R4 R5: status and latch
    op1(8'h04); stat_read(3, 8'hA5);
    c = ncmd;
    op1(8'h06); stat_read(2, 8'hA7);
    op1(8'h04); stat_read(1, 8'hA5);
    check(ncmd == c, "R5 latch ops silent", ncmd - c, 0);

    // R6: guarded commands refused
    c = ncmd; w = nwr;
    begin_cs; send_byte(8'h02); send_byte(8'h00); send_byte(8'h00); send_byte(8'h10);
    send_byte(8'h5A); send_byte(8'h5B); end_cs;
    begin_cs; send_byte(8'h20); send_byte(8'h00); send_byte(8'h10); send_byte(8'h00); end_cs;
    begin_cs; send_byte(8'hD8); send_byte(8'h01); send_byte(8'h00); send_byte(8'h00); end_cs;
    op1(8'hC7);
    check(ncmd == c && nwr == w, "R6 refused without latch", {ncmd - c, nwr - w}, 0);

    // R7 R8: program accepted
    op1(8'h06);
    w = nwr;
    begin_cs; send_byte(8'h02); send_byte(8'h00); send_byte(8'h20); send_byte(8'h00);
    check(cmd_valid && cmd_op == 8'h02 && cmd_addr == 24'h002000, "R8 program issue", cmd_addr, 24'h002000);
    send_byte(8'h11); send_byte(8'h22); send_byte(8'h33); end_cs;
    check(nwr - w == 3, "R8 write count", nwr - w, 3);
    check(wbuf[w] == 8'h11 && wbuf[w+1] == 8'h22 && wbuf[w+2] == 8'h33, "R8 write data",
          {wbuf[w], wbuf[w+1], wbuf[w+2]}, 24'h112233);
    stat_read(1, 8'hA5); // R7 latch gone

    // R8: cap at 256 bytes
    op1(8'h06);
    w = nwr;
    begin_cs; send_byte(8'h02); send_byte(8'h00); send_byte(8'h00); send_byte(8'h00);
    for (int k = 0; k < 258; k++) send_byte(8'(k));
    end_cs;
    check(nwr - w == 256, "R8 cap", nwr - w, 256);
    check(wbuf[w+255] == 8'hFF, "R8 last byte", wbuf[w+255], 8'hFF);

    // R7: erases clear the latch
    op1(8'h06);
    begin_cs; send_byte(8'h20); send_byte(8'h01); send_byte(8'h23); send_byte(8'h45);
    check(cmd_valid && cmd_op == 8'h20 && cmd_addr == 24'h012345, "R7 sector erase", cmd_addr, 24'h012345);
    end_cs;
    stat_read(1, 8'hA5);
    op1(8'h06);
    begin_cs; send_byte(8'hD8); send_byte(8'h0F); send_byte(8'h00); send_byte(8'h00);
    check(cmd_valid && cmd_op == 8'hD8, "R7 block erase", cmd_op, 8'hD8);
    end_cs;
    op1(8'h06);
    begin_cs; send_byte(8'hC7);
    check(cmd_valid && cmd_op == 8'hC7, "R7 chip erase", cmd_op, 8'hC7);
    end_cs;
    stat_read(1, 8'hA5);

    // R9: aborts
    op1(8'h06);
    c = ncmd;
    begin_cs; send_byte(8'h20); send_byte(8'h01); nib(4'h2); end_cs;
    check(ncmd == c, "R9 aborted erase", ncmd - c, 0);
    begin_cs; nib(4'h0); end_cs;
    stat_read(1, 8'hA7);
    op1(8'h04);

    // R10: reset arm
    c = ncmd;
    op1(8'h99);
    check(ncmd == c, "R10 unarmed reset", ncmd - c, 0);
    op1(8'h66);
    begin_cs; send_byte(8'h99);
    check(cmd_valid && cmd_op == 8'h99, "R10 armed reset", cmd_op, 8'h99);
    end_cs;
    c = ncmd;
    op1(8'h66); op1(8'h00); op1(8'h99);
    check(ncmd == c, "R10 arm cancelled", ncmd - c, 0);

    // R12 R13
    begin_cs; send_byte(8'hC0); send_byte(8'h5E);
    check(cmd_valid && cmd_op == 8'hC0 && cmd_arg == 8'h5E, "R12 burst arg", cmd_arg, 8'h5E);
    @(negedge sck);
    check(cmd_valid === 1'b0, "R13 single pulse", cmd_valid, 0);
    end_cs;
    begin_cs; send_byte(8'hB0);
    check(cmd_valid && cmd_op == 8'hB0, "R12 suspend", cmd_op, 8'hB0);
    end_cs;

    // R11: sweep every opcode with the latch clear and no arm
    for (int op = 0; op < 256; op++) begin
      int ec;
      bit eo;
      op1(8'h04);
      c = ncmd; w = nwr; seen_oe = 0;
      begin_cs;
      send_byte(8'(op));
      send_byte(8'h11); send_byte(8'h22); send_byte(8'h33); send_byte(8'h44); send_byte(8'h55);
      repeat (2) @(negedge sck);
      end_cs;
      ec = (op == 8'h03 || op == 8'h0B || op == 8'hB0 || op == 8'h30 || op == 8'hC0) ? 1 : 0;
      eo = (op == 8'h03 || op == 8'h0B || op == 8'h05);
      check(ncmd - c == ec && seen_oe == eo && nwr == w, "R11 opcode sweep",
            {op[7:0], 4'(ncmd - c), 3'd0, seen_oe}, {op[7:0], 4'(ec), 3'd0, eo});
    end

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge sck);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule